// File: doc/BRIEF.md
# CAN Error Status and Interrupt Register

This block is the host-visible error and status word of a CAN node. The protocol engine feeds it its receive error count, whether the bus is idle and whether the node is sending or receiving, the node's fault confinement state, bit-error and other error events, and the raw bus receive line. The block registers these into one status word that the host reads, and it keeps three sticky interrupt flags: one for entry into bus off, one for any error event and one for bus activity while the node sleeps.

Each flag is paired with a mask bit, and the masked flags are combined into a single registered interrupt request. The host clears a flag with a two-step handshake: it must first read the flag while it is one (a read strobe arms that bit), and only a later write of zero to that bit clears it. A soft reset issued while the node is bus off clears the whole word. The bus receive line is synchronised on entry, and the wake flag responds to a recessive-to-dominant edge only while the node is in low-power stop mode.

Top module: `can_esr`

## Requirements
- R1: Status bit 9 (receive warning) reads 1 one clock after the receive error count is 96 or more, and 0 one clock after it is below 96.
- R2: Status bit 8 mirrors the bus-idle input and status bit 7 mirrors the transmit-direction input (1 = transmitting, 0 = receiving), each one clock later.
- R3: Status bits [6:5] mirror the two-bit fault state input one clock later; codes 00 and 01 are the active and passive states, and any code with bit 1 set is bus off.
- R4: The bus-off flag (status bit 2) sets in the clock where the fault state first enters bus off, and does not set again while the state stays bus off after the host cleared it.
- R5: A soft reset while the fault state input is bus off clears every status bit, including the flags and the fault state field, and does not re-raise the bus-off flag; a soft reset outside bus off has no effect.
- R6: The error flag (status bit 1) sets one clock after any bit-error or other error event.
- R7: Status bits [4:3] hold the transmit bit-error code: 01 for a dominant bit read back recessive, 10 for a recessive bit read back dominant, 01 when both occur together, never 11; the code holds until a host read and then returns to 00 unless a new event arrives.
- R8: A write of 0 to a flag bit (write data bit 0 = wake, 1 = error, 2 = bus off) clears that flag only if the host has read the flag as 1 since it was set; an unarmed write of 0 and any write of 1 leave the flag unchanged.
- R9: A flag-setting event in the same clock as an armed clearing write leaves the flag set.
- R10: The wake flag (status bit 0) sets on a 1-to-0 edge of the bus receive line only while stop mode is asserted, three clocks after the edge is presented; outside stop mode such an edge leaves it clear.
- R11: The interrupt output is the OR of each flag ANDed with its mask bit (mask bits use the flag positions), registered, so it follows a flag or mask change one clock later; it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset request from the host |
| stop_mode | input | 1 | Node is in low-power stop mode |
| rx_err_cnt | input | CNT_W | Receive error count |
| bus_idle | input | 1 | Bus is idle |
| bus_tx | input | 1 | Node is transmitting (1) or receiving (0) |
| fault_state | input | 2 | Fault confinement state, bit 1 set = bus off |
| bit_err_dom | input | 1 | Dominant bit sent, recessive read back |
| bit_err_rec | input | 1 | Recessive bit sent, dominant read back |
| other_err | input | 1 | Any other protocol error event |
| can_rx | input | 1 | Asynchronous bus receive line, 1 = recessive |
| rd_en | input | 1 | Host read strobe of the status word |
| wr_en | input | 1 | Host write strobe for the flag bits |
| wr_flags | input | 3 | Host write data for the flag bits |
| irq_mask | input | 3 | Per-flag interrupt enable |
| status_o | output | 10 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the interrupt output equals the masked flags of the previous clock, that the receive-warning bit tracks the previous count against the threshold, that a flag only falls after a zero write or a soft reset in bus off, that the bus-off and wake flags only rise after bus-off entry or with stop mode active, and that the bit-error code never shows 11. Only the directed scenarios can show the arming handshake as a sequence, the priority of a new event over a clearing write, the exact three-clock wake latency, the hold-until-read behaviour of the bit-error code and the absence of a second bus-off flag after a soft reset.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
    localparam int NFLAG     = 3;
    localparam int FLAG_WAKE = 0;
    localparam int FLAG_ERR  = 1;
    localparam int FLAG_BOFF = 2;

    localparam int STAT_W    = 10;
    localparam int POS_BE_LO = 3;
    localparam int POS_FS_LO = 5;
    localparam int POS_DIR   = 7;
    localparam int POS_IDLE  = 8;
    localparam int POS_WARN  = 9;

    typedef enum logic [1:0] {
        BE_NONE       = 2'b00,
        BE_DOM_AS_REC = 2'b01,
        BE_REC_AS_DOM = 2'b10
    } biterr_e;
endpackage

// File: rtl/can_esr_rxsync.sv
module can_esr_rxsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sh   = {sync_q.sh[STAGES-2:0], rx_i};
        sync_d.last = sync_q.sh[STAGES-1];
        fall_o      = sync_q.last & ~sync_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/can_esr_flag.sv
module can_esr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_all_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic arm;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i && st_q.flag) st_d.arm = 1'b1;
        if (wr_i && !wr_bit_i && st_q.arm) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end
        if (set_i) st_d.flag = 1'b1;
        if (clr_all_i) st_d = '0;
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/can_esr.sv
module can_esr
    import can_esr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WARN_LEVEL  = 96,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop_mode,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             bus_idle,
    input  logic             bus_tx,
    input  logic [1:0]       fault_state,
    input  logic             bit_err_dom,
    input  logic             bit_err_rec,
    input  logic             other_err,
    input  logic             can_rx,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [NFLAG-1:0] wr_flags,
    input  logic [NFLAG-1:0] irq_mask,
    output logic [STAT_W-1:0] status_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_LEVEL);

    typedef struct packed {
        logic       rxwarn;
        logic       idle;
        logic       dir;
        logic [1:0] fs;
        biterr_e    biterr;
        logic       boff_seen;
        logic       irq;
    } regs_t;

    regs_t            r_d, r_q;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flags;
    logic             wake_fall;
    logic             soft_clr;

    can_esr_rxsync #(.STAGES(SYNC_STAGES)) u_rxsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (can_rx),
        .fall_o (wake_fall)
    );

    always_comb begin
        soft_clr            = soft_rst & fault_state[1];
        flag_set            = '0;
        flag_set[FLAG_WAKE] = wake_fall & stop_mode;
        flag_set[FLAG_ERR]  = bit_err_dom | bit_err_rec | other_err;
        flag_set[FLAG_BOFF] = fault_state[1] & ~r_q.boff_seen;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        can_esr_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (flag_set[i]),
            .clr_all_i (soft_clr),
            .rd_i      (rd_en),
            .wr_i      (wr_en),
            .wr_bit_i  (wr_flags[i]),
            .flag_o    (flags[i])
        );
    end

    always_comb begin
        r_d           = r_q;
        r_d.rxwarn    = (rx_err_cnt >= WARN_CNT);
        r_d.idle      = bus_idle;
        r_d.dir       = bus_tx;
        r_d.fs        = fault_state;
        r_d.boff_seen = fault_state[1];
        r_d.irq       = |(flags & irq_mask);
        if (bit_err_dom)      r_d.biterr = BE_DOM_AS_REC;
        else if (bit_err_rec) r_d.biterr = BE_REC_AS_DOM;
        else if (rd_en)       r_d.biterr = BE_NONE;
        if (soft_clr) begin
            r_d.rxwarn = 1'b0;
            r_d.idle   = 1'b0;
            r_d.dir    = 1'b0;
            r_d.fs     = 2'b00;
            r_d.biterr = BE_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        status_o                              = '0;
        status_o[NFLAG-1:0]                   = flags;
        status_o[POS_BE_LO +: 2]              = r_q.biterr;
        status_o[POS_FS_LO +: 2]              = r_q.fs;
        status_o[POS_DIR]                     = r_q.dir;
        status_o[POS_IDLE]                    = r_q.idle;
        status_o[POS_WARN]                    = r_q.rxwarn;
        irq_o                                 = r_q.irq;
    end
endmodule

// File: rtl/can_esr_chk.sv
module can_esr_chk
    import can_esr_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WARN_LEVEL = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              stop_mode,
    input logic [CNT_W-1:0]  rx_err_cnt,
    input logic [1:0]        fault_state,
    input logic              wr_en,
    input logic [NFLAG-1:0]  wr_flags,
    input logic [NFLAG-1:0]  irq_mask,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R11: request equals previous masked flags
    a_r11_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|(status_o[NFLAG-1:0] & irq_mask))));

    // R1: warning bit follows the previous count
    a_r1_rx_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(soft_rst && fault_state[1]))
        |-> (status_o[POS_WARN] == ($past(rx_err_cnt) >= CNT_W'(WARN_LEVEL))));

    // R4: bus-off flag rises only after the input was bus off
    a_r4_boff_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(status_o[FLAG_BOFF])) |-> $past(fault_state[1]));

    // R10: wake flag rises only with stop mode
    a_r10_wake_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(status_o[FLAG_WAKE])) |-> $past(stop_mode));

    // R7: bit-error code 11 never appears
    a_r7_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[POS_BE_LO +: 2] != 2'b11);

    for (genvar i = 0; i < NFLAG; i++) begin : g_fall
        // R8 and R5: a flag only falls after a zero write or a soft clear
        a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $fell(status_o[i]))
            |-> ($past(wr_en && !wr_flags[i]) || $past(soft_rst && fault_state[1])));
    end
endmodule

bind can_esr can_esr_chk #(.CNT_W(CNT_W), .WARN_LEVEL(WARN_LEVEL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .stop_mode   (stop_mode),
    .rx_err_cnt  (rx_err_cnt),
    .fault_state (fault_state),
    .wr_en       (wr_en),
    .wr_flags    (wr_flags),
    .irq_mask    (irq_mask),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/can_esr_tb.sv
module can_esr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       stop_mode = 1'b0;
    logic [7:0] rx_err_cnt = '0;
    logic       bus_idle = 1'b0;
    logic       bus_tx = 1'b0;
    logic [1:0] fault_state = 2'b00;
    logic       bit_err_dom = 1'b0;
    logic       bit_err_rec = 1'b0;
    logic       other_err = 1'b0;
    logic       can_rx = 1'b1;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_flags = '0;
    logic [2:0] irq_mask = '0;
    logic [9:0] status_o;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    can_esr u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_mode(stop_mode),
        .rx_err_cnt(rx_err_cnt), .bus_idle(bus_idle), .bus_tx(bus_tx),
        .fault_state(fault_state), .bit_err_dom(bit_err_dom),
        .bit_err_rec(bit_err_rec), .other_err(other_err), .can_rx(can_rx),
        .rd_en(rd_en), .wr_en(wr_en), .wr_flags(wr_flags), .irq_mask(irq_mask),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_read(output logic [9:0] v);
        v = status_o;
        rd_en = 1'b1;
        step(1);
        rd_en = 1'b0;
    endtask

    task automatic host_write(logic [2:0] d);
        wr_en = 1'b1;
        wr_flags = d;
        step(1);
        wr_en = 1'b0;
        wr_flags = '0;
    endtask

    task automatic pulse_err();
        other_err = 1'b1;
        step(1);
        other_err = 1'b0;
    endtask

    task automatic clear_err();
        logic [9:0] v;
        host_read(v);
        host_write(3'b101);
    endtask

    task automatic t_reset();
        chk("R11 reset status", 32'(status_o), 32'h0);
        chk("R11 reset irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_rxwarn();
        rx_err_cnt = 8'd95;  step(1); chk("R1 count 95", 32'(status_o[9]), 32'h0);
        rx_err_cnt = 8'd96;  step(1); chk("R1 count 96", 32'(status_o[9]), 32'h1);
        rx_err_cnt = 8'd200; step(1); chk("R1 count 200", 32'(status_o[9]), 32'h1);
        rx_err_cnt = 8'd0;   step(1); chk("R1 count 0", 32'(status_o[9]), 32'h0);
    endtask

    task automatic t_idle_dir();
        bus_idle = 1'b1; step(1); chk("R2 idle", 32'(status_o[8]), 32'h1);
        bus_idle = 1'b0; bus_tx = 1'b1; step(1);
        chk("R2 busy", 32'(status_o[8]), 32'h0);
        chk("R2 transmit", 32'(status_o[7]), 32'h1);
        bus_tx = 1'b0; step(1); chk("R2 receive", 32'(status_o[7]), 32'h0);
    endtask

    task automatic t_fault();
        logic [9:0] v;
        fault_state = 2'b01; step(1);
        chk("R3 passive field", 32'(status_o[6:5]), 32'h1);
        chk("R4 no flag when passive", 32'(status_o[2]), 32'h0);
        fault_state = 2'b10; step(1);
        chk("R3 bus off field", 32'(status_o[6:5]), 32'h2);
        chk("R4 bus off entry sets flag", 32'(status_o[2]), 32'h1);
        host_read(v);
        chk("R4 read shows flag", 32'(v[2]), 32'h1);
        host_write(3'b011);
        chk("R4 flag cleared", 32'(status_o[2]), 32'h0);
        step(3);
        chk("R4 staying bus off no re-set", 32'(status_o[2]), 32'h0);
    endtask

    task automatic t_softrst();
        pulse_err();
        chk("R5 error flag before soft reset", 32'(status_o[1]), 32'h1);
        soft_rst = 1'b1; step(1); soft_rst = 1'b0;
        chk("R5 soft reset clears word", 32'(status_o), 32'h0);
        step(1);
        chk("R5 field back, bus-off flag stays clear", 32'(status_o), 32'h040);
        fault_state = 2'b00; step(1);
        pulse_err();
        soft_rst = 1'b1; step(1); soft_rst = 1'b0;
        chk("R5 soft reset outside bus off ignored", 32'(status_o[1]), 32'h1);
        clear_err();
        chk("R5 cleanup", 32'(status_o[1]), 32'h0);
    endtask

    task automatic t_err();
        logic [9:0] v;
        pulse_err();
        chk("R6 other error sets flag", 32'(status_o[1]), 32'h1);
        chk("R7 other error leaves code", 32'(status_o[4:3]), 32'h0);
        clear_err();
        bit_err_dom = 1'b1; step(1); bit_err_dom = 1'b0;
        chk("R6 bit error sets flag", 32'(status_o[1]), 32'h1);
        chk("R7 dominant read recessive", 32'(status_o[4:3]), 32'h1);
        step(2);
        chk("R7 code holds", 32'(status_o[4:3]), 32'h1);
        host_read(v);
        chk("R7 read returns code", 32'(v[4:3]), 32'h1);
        chk("R7 cleared after read", 32'(status_o[4:3]), 32'h0);
        bit_err_rec = 1'b1; step(1); bit_err_rec = 1'b0;
        chk("R7 recessive read dominant", 32'(status_o[4:3]), 32'h2);
        bit_err_dom = 1'b1; bit_err_rec = 1'b1; step(1);
        bit_err_dom = 1'b0; bit_err_rec = 1'b0;
        chk("R7 both events", 32'(status_o[4:3]), 32'h1);
        host_read(v);
        host_write(3'b101);
        chk("R6 cleanup", 32'(status_o[1]), 32'h0);
    endtask

    task automatic t_clear();
        logic [9:0] v;
        pulse_err();
        host_write(3'b000);
        chk("R8 unarmed zero write ignored", 32'(status_o[1]), 32'h1);
        host_read(v);
        host_write(3'b111);
        chk("R8 write of one ignored", 32'(status_o[1]), 32'h1);
        host_write(3'b000);
        chk("R8 armed zero write clears", 32'(status_o[1]), 32'h0);
    endtask

    task automatic t_setwins();
        logic [9:0] v;
        pulse_err();
        host_read(v);
        other_err = 1'b1;
        host_write(3'b000);
        other_err = 1'b0;
        chk("R9 set beats clear", 32'(status_o[1]), 32'h1);
        clear_err();
        chk("R9 cleanup", 32'(status_o[1]), 32'h0);
    endtask

    task automatic t_wake();
        stop_mode = 1'b0; can_rx = 1'b0; step(4);
        chk("R10 edge outside stop mode", 32'(status_o[0]), 32'h0);
        can_rx = 1'b1; step(4);
        stop_mode = 1'b1; can_rx = 1'b0; step(2);
        chk("R10 not yet after two clocks", 32'(status_o[0]), 32'h0);
        step(1);
        chk("R10 set after three clocks", 32'(status_o[0]), 32'h1);
        can_rx = 1'b1; stop_mode = 1'b0; step(3);
        chk("R10 flag sticky", 32'(status_o[0]), 32'h1);
    endtask

    task automatic t_irq();
        logic [9:0] v;
        pulse_err();
        irq_mask = 3'b000; step(1);
        chk("R11 masked off", 32'(irq_o), 32'h0);
        irq_mask = 3'b001; step(1);
        chk("R11 wake mask on", 32'(irq_o), 32'h1);
        host_read(v);
        host_write(3'b110);
        chk("R11 wake flag cleared", 32'(status_o[0]), 32'h0);
        chk("R11 request lags one clock", 32'(irq_o), 32'h1);
        step(1);
        chk("R11 request drops", 32'(irq_o), 32'h0);
        irq_mask = 3'b010; step(1);
        chk("R11 error mask on", 32'(irq_o), 32'h1);
        irq_mask = 3'b000; step(1);
        chk("R11 mask off again", 32'(irq_o), 32'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_rxwarn();
        t_idle_dir();
        t_fault();
        t_softrst();
        t_err();
        t_clear();
        t_setwins();
        t_wake();
        t_irq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule